// File: doc/BRIEF.md
# Shared Cache Way Resize Controller

This controller sets how many ways of a 16-way shared cache are switched on. Ways are enabled and disabled in groups of four, so the cache can run with 4, 8, 12 or 16 ways. For a 2 MB cache these settings give 512, 1024, 1536 and 2048 KB. The number of sets and the tag width never change. A policy block outside this controller picks the way count. The controller takes that request, rounds it to a legal setting and carries out the change.

Growing takes effect at once. The added ways are powered up and enabled, and their tags are invalidated in a single pulse. No flush is needed. Shrinking happens in three steps. First the departing ways are removed from the allocation mask. Then the controller walks every set in ascending order, reads the valid and dirty bits of that set, and issues one write-back at a time over a valid/ready handshake for each dirty line in a departing way. Only when the walk is over are the departing ways power-gated and completion signalled. A request that arrives during a flush is held and served after completion.

Top module: `way_rsz_ctrl`

## Requirements
- R1: After reset all 16 ways are enabled and powered, wb_valid_o is low, done_o is low and inv_ways_o is zero.
- R2: A requested count is rounded up to the next multiple of four, with 0 becoming 4 and anything above 16 becoming 16. N enabled ways are always ways 0 to N-1, and bit i of every way mask refers to way i.
- R3: A request sampled at clock edge E while idle is applied at edge E+1.
- R4: A grow sets way_en_o and pwr_en_o to the new mask. In the same cycle it pulses done_o and pulses inv_ways_o with exactly the added ways, for one cycle. It issues no write-back.
- R5: A shrink drops way_en_o to the new mask when it is applied. pwr_en_o keeps the old mask for the whole flush, and an enabled way is never unpowered.
- R6: Write-backs are issued only for lines that are both valid and dirty in a departing way. They come in ascending set order starting at set 0, and lowest way first within a set. Each such line is written exactly once.
- R7: While wb_valid_o is high and wb_ready_i is low, wb_valid_o, wb_set_o and wb_way_o hold steady.
- R8: After the last set has been walked, done_o pulses for one cycle and pwr_en_o drops to the new mask in that same cycle.
- R9: A request that arrives during a flush has no effect on way_en_o until done_o. It is applied one cycle after done_o.
- R10: A request equal to the current setting pulses done_o one cycle after capture and changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Resize request strobe |
| req_ways_i | input | 5 | Requested way count, rounded up to a legal setting |
| scan_set_o | output | 5 | Set whose tag bits are being read |
| tag_valid_i | input | 16 | Valid bits of set scan_set_o, one per way |
| tag_dirty_i | input | 16 | Dirty bits of set scan_set_o, one per way |
| wb_valid_o | output | 1 | Write-back request valid |
| wb_ready_i | input | 1 | Write-back request accepted |
| wb_set_o | output | 5 | Set index of the line to write back |
| wb_way_o | output | 4 | Way index of the line to write back |
| way_en_o | output | 16 | Ways open for allocation and lookup |
| pwr_en_o | output | 16 | Ways powered |
| inv_ways_o | output | 16 | One-cycle pulse: invalidate these ways in every set |
| done_o | output | 1 | One-cycle pulse when a resize completes |

## Verification
Suppose the walker's set counter or its record of lines already written goes wrong. The result shows up within a cycle or two at the write-back port: a line is written twice, one is skipped, or requests come out of order. The scoreboard catches each of these. Suppose instead the mode logic goes wrong. Then either ways lose power before their dirty lines have left, or done_o comes at the wrong time. Both are seen on pwr_en_o and done_o in the cycle of the fault. A request held during a flush that was mishandled shows up as a change in way_en_o before done_o, or as a missing change one cycle after it.

// File: rtl/way_rsz_pkg.sv
package way_rsz_pkg;
  typedef enum logic {ST_IDLE, ST_FLUSH} rsz_state_e;
endpackage

// File: rtl/way_rsz_req_hold.sv
module way_rsz_req_hold #(
  parameter int NUM_WAYS = 16,
  parameter int GROUP    = 4,
  localparam int CNT_W   = $clog2(NUM_WAYS) + 1,
  localparam int NUM_GRP = NUM_WAYS / GROUP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [CNT_W-1:0]    req_ways_i,
  input  logic                take_i,
  output logic                hold_vld_o,
  output logic [NUM_WAYS-1:0] hold_mask_o
);
  int                grp;
  logic [NUM_WAYS-1:0] new_mask;

  always_comb begin
    grp = (int'(req_ways_i) + GROUP - 1) / GROUP;
    if (grp < 1) grp = 1;
    if (grp > NUM_GRP) grp = NUM_GRP;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
    localparam int GI = w / GROUP;
    assign new_mask[w] = (grp > GI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_o  <= 1'b0;
      hold_mask_o <= '0;
    end else if (req_valid_i) begin
      hold_vld_o  <= 1'b1;
      hold_mask_o <= new_mask;
    end else if (take_i) begin
      hold_vld_o  <= 1'b0;
    end
  end

  // R9: a request is never lost
  p_req_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> hold_vld_o);
endmodule

// File: rtl/way_rsz_flush_walk.sv
module way_rsz_flush_walk #(
  parameter int NUM_WAYS = 16,
  parameter int NUM_SETS = 32,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [NUM_WAYS-1:0] depart_i,
  input  logic [NUM_WAYS-1:0] tag_valid_i,
  input  logic [NUM_WAYS-1:0] tag_dirty_i,
  input  logic                wb_ready_i,
  output logic [SET_W-1:0]    set_o,
  output logic                wb_valid_o,
  output logic [WAY_W-1:0]    wb_way_o,
  output logic                fin_o
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0]    set_q;
  logic [NUM_WAYS-1:0] served_q, pending, pick_oh;
  logic [WAY_W-1:0]    pick_idx;

  assign pending = tag_valid_i & tag_dirty_i & depart_i & ~served_q;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (pending[w]) begin
        pick_oh    = '0;
        pick_oh[w] = 1'b1;
        pick_idx   = WAY_W'(w);
      end
    end
  end

  assign set_o      = set_q;
  assign wb_valid_o = run_i && (|pending);
  assign wb_way_o   = pick_idx;
  assign fin_o      = run_i && !(|pending) && (set_q == LAST_SET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q    <= '0;
      served_q <= '0;
    end else if (!run_i) begin
      set_q    <= '0;
      served_q <= '0;
    end else if (|pending) begin
      if (wb_ready_i) served_q <= served_q | pick_oh;
    end else if (set_q != LAST_SET) begin
      set_q    <= set_q + 1'b1;
      served_q <= '0;
    end
  end

  // R6: walk never skips or revisits a set
  p_set_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i) |-> (set_q == $past(set_q) || set_q == $past(set_q) + 1'b1));
  // R7: request held until accepted
  p_wb_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_way_o) && $stable(set_o)));
endmodule

// File: rtl/way_rsz_ctrl.sv
module way_rsz_ctrl
  import way_rsz_pkg::*;
#(
  parameter int NUM_WAYS = 16,
  parameter int GROUP    = 4,
  parameter int NUM_SETS = 32,
  localparam int CNT_W   = $clog2(NUM_WAYS) + 1,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [CNT_W-1:0]    req_ways_i,
  output logic [SET_W-1:0]    scan_set_o,
  input  logic [NUM_WAYS-1:0] tag_valid_i,
  input  logic [NUM_WAYS-1:0] tag_dirty_i,
  output logic                wb_valid_o,
  input  logic                wb_ready_i,
  output logic [SET_W-1:0]    wb_set_o,
  output logic [WAY_W-1:0]    wb_way_o,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic [NUM_WAYS-1:0] pwr_en_o,
  output logic [NUM_WAYS-1:0] inv_ways_o,
  output logic                done_o
);
  rsz_state_e          state_q;
  logic [NUM_WAYS-1:0] way_en_q, pwr_en_q, inv_q, depart_q, hold_mask;
  logic                done_q, hold_vld, take, fin;

  assign take = (state_q == ST_IDLE) && hold_vld;

  way_rsz_req_hold #(.NUM_WAYS(NUM_WAYS), .GROUP(GROUP)) u_hold (
    .clk_i, .rst_ni, .req_valid_i, .req_ways_i,
    .take_i      (take),
    .hold_vld_o  (hold_vld),
    .hold_mask_o (hold_mask)
  );

  way_rsz_flush_walk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_walk (
    .clk_i, .rst_ni,
    .run_i       (state_q == ST_FLUSH),
    .depart_i    (depart_q),
    .tag_valid_i, .tag_dirty_i, .wb_ready_i,
    .set_o       (scan_set_o),
    .wb_valid_o,
    .wb_way_o,
    .fin_o       (fin)
  );

  assign wb_set_o   = scan_set_o;
  assign way_en_o   = way_en_q;
  assign pwr_en_o   = pwr_en_q;
  assign inv_ways_o = inv_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      way_en_q <= '1;
      pwr_en_q <= '1;
      inv_q    <= '0;
      depart_q <= '0;
      done_q   <= 1'b0;
    end else begin
      inv_q  <= '0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (|(hold_mask & ~way_en_q)) begin
            // grow: enable, power and invalidate the new ways together
            way_en_q <= hold_mask;
            pwr_en_q <= hold_mask;
            inv_q    <= hold_mask & ~way_en_q;
            done_q   <= 1'b1;
          end else if (hold_mask == way_en_q) begin
            done_q   <= 1'b1;
          end else begin
            way_en_q <= hold_mask;
            depart_q <= way_en_q & ~hold_mask;
            state_q  <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (fin) begin
          pwr_en_q <= way_en_q;
          depart_q <= '0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: an enabled way is always powered
  p_en_powered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (way_en_o & ~pwr_en_o) == '0);
  // R6: write-backs target only ways already closed to allocation
  p_wb_departing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !way_en_o[wb_way_o]);
  // R8: ways lose power only when completion is flagged
  p_gate_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pwr_en_o) & ~pwr_en_o)) |-> done_o);
  // R4: invalidation only with a completed grow
  p_inv_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|inv_ways_o) |-> (done_o && (inv_ways_o & ~way_en_o) == '0));
endmodule

// File: tb/tb_way_rsz_ctrl.sv
module tb_way_rsz_ctrl;
  localparam int NW = 16;
  localparam int NS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [4:0]  req_ways = '0;
  logic [4:0]  scan_set, wb_set;
  logic [15:0] tag_valid, tag_dirty, way_en, pwr_en, inv_ways;
  logic        wb_valid, wb_ready = 1'b0, done;
  logic [3:0]  wb_way;

  logic [15:0] vld_arr [NS];
  logic [15:0] drt_arr [NS];
  assign tag_valid = vld_arr[scan_set];
  assign tag_dirty = drt_arr[scan_set];

  way_rsz_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ways_i(req_ways),
    .scan_set_o(scan_set), .tag_valid_i(tag_valid), .tag_dirty_i(tag_dirty),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_set_o(wb_set), .wb_way_o(wb_way),
    .way_en_o(way_en), .pwr_en_o(pwr_en), .inv_ways_o(inv_ways), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  int exp_q [$];
  int cyc = 0;
  logic prev_stall = 1'b0;
  int   prev_item = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: ready pattern, scoreboard of write-backs, hold-stable check
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall) chk("R7 wb held while stalled", wb_valid ? (wb_set * 16 + wb_way) : -1, prev_item);
      wb_ready = (cyc % 3) != 0;
      if (wb_valid && wb_ready) begin
        if (exp_q.size() == 0) chk("R6 unexpected write-back", wb_set * 16 + wb_way, -1);
        else chk("R6 write-back order", wb_set * 16 + wb_way, exp_q.pop_front());
      end
      prev_stall = wb_valid && !wb_ready;
      prev_item  = wb_set * 16 + wb_way;
    end
  end

  function automatic logic [15:0] mask_of(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic fill_tags(input int seed);
    int x = seed;
    for (int s = 0; s < NS; s++) begin
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      vld_arr[s] = x[23:8];
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      drt_arr[s] = x[23:8];
    end
  endtask

  task automatic build_exp(input logic [15:0] dep);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (dep[w] && vld_arr[s][w] && drt_arr[s][w]) exp_q.push_back(s * 16 + w);
  endtask

  task automatic send_req(input int v);
    @(negedge clk);
    req_valid = 1'b1;
    req_ways  = 5'(v);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input logic [15:0] old_pwr, input string req);
    int i;
    int held_bad = 0;
    for (i = 0; i < 3000; i++) begin
      if (done) break;
      if (pwr_en != old_pwr) held_bad++;
      @(negedge clk);
    end
    chk({req, " done reached"}, i < 3000, 1);
    chk("R5 power kept during flush", held_bad, 0);
  endtask

  task automatic shrink(input int v, input int n_new, input int seed);
    logic [15:0] old = way_en;
    fill_tags(seed);
    build_exp(old & ~mask_of(n_new));
    send_req(v);
    @(negedge clk);
    chk("R2/R3/R5 way_en at start of shrink", way_en, mask_of(n_new));
    chk("R5 power unchanged at start", pwr_en, old);
    wait_done(old, "R8");
    chk("R8 power gated at done", pwr_en, mask_of(n_new));
    chk("R6 all dirty lines written", exp_q.size(), 0);
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
  endtask

  initial begin
    fill_tags(7);
    repeat (3) @(negedge clk);
    chk("R1 way_en reset", way_en, 16'hffff);
    chk("R1 pwr_en reset", pwr_en, 16'hffff);
    chk("R1 wb_valid reset", wb_valid, 0);
    chk("R1 done reset", done, 0);
    chk("R1 inv reset", inv_ways, 0);
    rst_n = 1'b1;
    @(negedge clk);

    shrink(12, 12, 11);

    // grow 12 -> 16
    send_req(16);
    chk("R3 no change before apply edge", way_en, 16'h0fff);
    @(negedge clk);
    chk("R4 grow way_en", way_en, 16'hffff);
    chk("R4 grow pwr_en", pwr_en, 16'hffff);
    chk("R4 inv added ways", inv_ways, 16'hf000);
    chk("R4 grow done", done, 1);
    chk("R4 no write-back on grow", wb_valid, 0);
    @(negedge clk);
    chk("R4 inv single pulse", inv_ways, 0);

    shrink(5, 8, 23);   // R2: 5 rounds to 8

    // R9: shrink to 4 (0 rounds up), request 20 arrives mid-flush
    begin
      fill_tags(41);
      build_exp(16'h00f0);
      send_req(0);
      @(negedge clk);
      chk("R2 zero rounds to 4", way_en, 16'h000f);
      send_req(20);
      chk("R9 held request ignored during flush", way_en, 16'h000f);
      wait_done(16'h00ff, "R9");
      chk("R9 way_en unchanged at done", way_en, 16'h000f);
      chk("R8 power gated to 4", pwr_en, 16'h000f);
      chk("R6 all dirty lines written", exp_q.size(), 0);
      @(negedge clk);
      chk("R9/R2 held request applied, 20 clamps to 16", way_en, 16'hffff);
      chk("R9 inv after held grow", inv_ways, 16'hfff0);
      chk("R9 done after held grow", done, 1);
    end

    // R10: equal request
    send_req(16);
    @(negedge clk);
    chk("R10 done on equal request", done, 1);
    chk("R10 way_en unchanged", way_en, 16'hffff);
    chk("R10 pwr_en unchanged", pwr_en, 16'hffff);
    chk("R10 no invalidation", inv_ways, 0);

    shrink(9, 12, 77);  // R2: 9 rounds to 12
    shrink(1, 4, 5);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule